// File: doc/BRIEF.md
# Micro-op Cache Supply Mode Controller

This block sits in a processor front end and decides, cycle by cycle, where decoded micro-ops come from. It has three modes. In the filter mode it waits for the small loop predictor to report that the current code segment is predictable and small enough for both the predictor and the micro-op cache. In the build mode it watches every prediction lookup: a lookup whose target block is not yet marked as built sends a tag probe to the micro-op cache and, one cycle later, either an allocation request or a built-bit update back to the predictor. In the fetch mode the instruction cache and decoders are switched off and the micro-op cache alone supplies the pipe.

Two saturating edge counters, one for lookups that found the built bit set and one for lookups that found it clear, steer the mode. Entry to the fetch mode needs a high ratio of built edges before a build timer expires; exit back to filter happens when the unbuilt edges grow past a second, lower ratio, or at once on a mispredict. Ratios are checked by scaling one counter with a constant, so no divider is needed. Once enough lookups in the fetch mode have passed without a mispredict, the main target buffer is also gated off.

Top module: `uoc_mode_ctrl`

## Requirements
- R1: After reset the mode is filter (encoding 2'b00), fetch_en and mbtb_en are 1, and tchk_vld, alloc_vld and bupd_vld are 0.
- R2: In filter mode, qual_ok high at a clock edge moves the mode to build (2'b01) at that edge; without qual_ok the mode stays filter.
- R3: In build or fetch mode, a lookup with look_built low raises tchk_vld with tchk_id equal to look_id in the same cycle; one cycle later alloc_vld (tag_present low) or bupd_vld (tag_present high) is raised with the same id, never both.
- R4: In build mode, when the registered built-edge count is at least MIN_FETCH and at least ENTER_MULT times the unbuilt-edge count, the mode becomes fetch (2'b10) at the next edge; filter never moves straight to fetch.
- R5: Each lookup in build mode advances a build timer; when it has reached BUILD_TIMEOUT the mode returns to filter at the next edge with all counts cleared, taking priority over R4.
- R6: In fetch mode fetch_en is 0; mbtb_en is 0 once ACC_RUN lookups have been seen during the current fetch visit, and 1 in every other mode.
- R7: Edge counts keep updating in fetch mode; when EXIT_MULT times the unbuilt count reaches the built count, the mode returns to filter at the next edge.
- R8: A mispredict in fetch mode returns the mode to filter at the next edge, where fetch_en is 1 again.
- R9: In filter mode lookups raise no tag probe and are not counted; a mispredict outside fetch mode does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| look_vld | input | 1 | A prediction lookup occurs this cycle |
| look_built | input | 1 | Built bit of the looked-up entry |
| look_id | input | ID_W | Identifier of the target basic block |
| qual_ok | input | 1 | Small predictor reports the segment predictable and fitting |
| tag_present | input | 1 | Result of the tag probe issued the previous cycle |
| mispredict | input | 1 | Small predictor mispredicted |
| mode | output | 2 | Current mode: 00 filter, 01 build, 10 fetch |
| tchk_vld | output | 1 | Tag probe request |
| tchk_id | output | ID_W | Block probed |
| alloc_vld | output | 1 | Allocate block in the micro-op cache |
| alloc_id | output | ID_W | Block to allocate |
| bupd_vld | output | 1 | Set the built bit in the predictor |
| bupd_id | output | ID_W | Block whose built bit is set |
| fetch_en | output | 1 | Instruction cache and decode enable |
| mbtb_en | output | 1 | Main target buffer enable |

## Verification
On every cycle the assertions check the legal mode steps (qualification into build, no jump from filter to fetch, mispredict out of fetch), the one-cycle pairing of each tag probe with exactly one allocation or built-bit update carrying the same id, and the gating of fetch and main-buffer enables by mode. The ratio thresholds, the minimum built count, the build-timer timeout and the hysteresis between entry and exit depend on accumulated counts, so only the bench scenarios, compared against its reference model each cycle, show that those transitions fall on the right edge.

// File: rtl/uoc_mode_pkg.sv
package uoc_mode_pkg;
   typedef enum logic [1:0] {
      UM_FILTER = 2'b00,
      UM_BUILD  = 2'b01,
      UM_FETCH  = 2'b10
   } uoc_mode_e;
endpackage

// File: rtl/uoc_sat_ctr.sv
// Saturating up-counter with synchronous clear.
module uoc_sat_ctr #(
   parameter int W   = 8,
   parameter int MAX = 255
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] LIM = W'(MAX);

   initial begin
      if (MAX < 1 || MAX > (2 ** W) - 1)
         $error("uoc_sat_ctr: MAX does not fit in W bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && cnt != LIM)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uoc_ratio_ge.sv
// Divider-free ratio compare. DIR=0: num >= MULT*den. DIR=1: MULT*den >= num.
module uoc_ratio_ge #(
   parameter int CNT_W = 8,
   parameter int MULT  = 4,
   parameter int DIR   = 0
) (
   input  logic [CNT_W-1:0] num,
   input  logic [CNT_W-1:0] den,
   output logic             hit
);
   localparam int MW = $clog2(MULT) + 1;
   localparam int PW = CNT_W + MW;
   localparam bit POW2 = ((MULT & (MULT - 1)) == 0);

   logic [PW-1:0] scaled;
   logic [PW-1:0] num_w;

   initial begin
      if (MULT < 1) $error("uoc_ratio_ge: MULT must be positive");
      if (DIR != 0 && DIR != 1) $error("uoc_ratio_ge: DIR must be 0 or 1");
   end

   assign num_w = PW'(num);

   generate
      if (POW2) begin : g_shift
         assign scaled = PW'(den) << $clog2(MULT);
      end else begin : g_mult
         assign scaled = PW'(den) * PW'(MULT);
      end
   endgenerate

   generate
      if (DIR == 0) begin : g_num_ge
         assign hit = (num_w >= scaled);
      end else begin : g_den_ge
         assign hit = (scaled >= num_w);
      end
   endgenerate
endmodule

// File: rtl/uoc_tag_stage.sv
// Holds a tag probe for one cycle and resolves it against the probe result.
module uoc_tag_stage #(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_vld,
   input  logic [ID_W-1:0] req_id,
   input  logic            tag_present,
   output logic            alloc_vld,
   output logic [ID_W-1:0] alloc_id,
   output logic            bupd_vld,
   output logic [ID_W-1:0] bupd_id
);
   logic            pend_vld;
   logic [ID_W-1:0] pend_id;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld <= 1'b0;
         pend_id  <= '0;
      end else begin
         pend_vld <= req_vld;
         if (req_vld) pend_id <= req_id;
      end
   end

   assign alloc_vld = pend_vld && !tag_present;
   assign bupd_vld  = pend_vld &&  tag_present;
   assign alloc_id  = pend_id;
   assign bupd_id   = pend_id;
endmodule

// File: rtl/uoc_mode_ctrl.sv
module uoc_mode_ctrl #(
   parameter int ID_W          = 8,
   parameter int CNT_W         = 8,
   parameter int BUILD_TIMEOUT = 64,
   parameter int ENTER_MULT    = 4,
   parameter int EXIT_MULT     = 2,
   parameter int MIN_FETCH     = 8,
   parameter int ACC_RUN       = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            look_vld,
   input  logic            look_built,
   input  logic [ID_W-1:0] look_id,
   input  logic            qual_ok,
   input  logic            tag_present,
   input  logic            mispredict,
   output logic [1:0]      mode,
   output logic            tchk_vld,
   output logic [ID_W-1:0] tchk_id,
   output logic            alloc_vld,
   output logic [ID_W-1:0] alloc_id,
   output logic            bupd_vld,
   output logic [ID_W-1:0] bupd_id,
   output logic            fetch_en,
   output logic            mbtb_en
);
   import uoc_mode_pkg::*;

   localparam int TMR_W = $clog2(BUILD_TIMEOUT + 1);
   localparam int ACC_W = $clog2(ACC_RUN + 1);
   localparam int CMAX  = (2 ** CNT_W) - 1;
   localparam logic [TMR_W-1:0] TMR_LIM = TMR_W'(BUILD_TIMEOUT);
   localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(ACC_RUN);
   localparam logic [CNT_W-1:0] MIN_F   = CNT_W'(MIN_FETCH);

   initial begin
      if (ENTER_MULT <= EXIT_MULT)
         $error("uoc_mode_ctrl: ENTER_MULT must exceed EXIT_MULT for hysteresis");
      if (MIN_FETCH < 1 || MIN_FETCH > CMAX)
         $error("uoc_mode_ctrl: MIN_FETCH out of counter range");
      if (BUILD_TIMEOUT < 1 || ACC_RUN < 1)
         $error("uoc_mode_ctrl: timeout and accuracy run must be positive");
   end

   uoc_mode_e        cur_q, nxt;
   logic [CNT_W-1:0] fedge, bedge;
   logic [TMR_W-1:0] btimer;
   logic [ACC_W-1:0] acc;
   logic             enter_hit, exit_hit, timed_out;
   logic             in_filter, in_build, in_fetch;
   logic             clr_cnt, clr_acc;

   assign in_filter = (cur_q == UM_FILTER);
   assign in_build  = (cur_q == UM_BUILD);
   assign in_fetch  = (cur_q == UM_FETCH);

   uoc_ratio_ge #(.CNT_W(CNT_W), .MULT(ENTER_MULT), .DIR(0)) u_enter (
      .num (fedge),
      .den (bedge),
      .hit (enter_hit)
   );

   uoc_ratio_ge #(.CNT_W(CNT_W), .MULT(EXIT_MULT), .DIR(1)) u_exit (
      .num (fedge),
      .den (bedge),
      .hit (exit_hit)
   );

   assign timed_out = (btimer >= TMR_LIM);

   always_comb begin
      nxt = cur_q;
      unique case (cur_q)
         UM_FILTER: if (qual_ok) nxt = UM_BUILD;
         UM_BUILD: begin
            if (timed_out)
               nxt = UM_FILTER;
            else if (enter_hit && fedge >= MIN_F)
               nxt = UM_FETCH;
         end
         UM_FETCH: if (mispredict || exit_hit) nxt = UM_FILTER;
         default: nxt = UM_FILTER;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= UM_FILTER;
      else        cur_q <= nxt;
   end

   assign clr_cnt = in_filter || (nxt == UM_FILTER);
   assign clr_acc = !in_fetch || (nxt != UM_FETCH);

   uoc_sat_ctr #(.W(CNT_W), .MAX(CMAX)) u_fedge (
      .clk (clk), .rst_n (rst_n), .clr (clr_cnt),
      .inc (look_vld && look_built), .cnt (fedge)
   );

   uoc_sat_ctr #(.W(CNT_W), .MAX(CMAX)) u_bedge (
      .clk (clk), .rst_n (rst_n), .clr (clr_cnt),
      .inc (look_vld && !look_built), .cnt (bedge)
   );

   uoc_sat_ctr #(.W(TMR_W), .MAX(BUILD_TIMEOUT)) u_btimer (
      .clk (clk), .rst_n (rst_n), .clr (clr_cnt),
      .inc (look_vld && in_build), .cnt (btimer)
   );

   uoc_sat_ctr #(.W(ACC_W), .MAX(ACC_RUN)) u_acc (
      .clk (clk), .rst_n (rst_n), .clr (clr_acc),
      .inc (look_vld && in_fetch), .cnt (acc)
   );

   assign tchk_vld = look_vld && !look_built && !in_filter;
   assign tchk_id  = look_id;

   uoc_tag_stage #(.ID_W(ID_W)) u_tag (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_vld     (tchk_vld),
      .req_id      (look_id),
      .tag_present (tag_present),
      .alloc_vld   (alloc_vld),
      .alloc_id    (alloc_id),
      .bupd_vld    (bupd_vld),
      .bupd_id     (bupd_id)
   );

   assign mode     = cur_q;
   assign fetch_en = !in_fetch;
   assign mbtb_en  = !(in_fetch && acc == ACC_LIM);
endmodule

// File: rtl/uoc_mode_chk.sv
module uoc_mode_chk #(
   parameter int ID_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            qual_ok,
   input logic            mispredict,
   input logic [1:0]      mode,
   input logic            tchk_vld,
   input logic [ID_W-1:0] tchk_id,
   input logic            alloc_vld,
   input logic [ID_W-1:0] alloc_id,
   input logic            bupd_vld,
   input logic [ID_W-1:0] bupd_id,
   input logic            fetch_en,
   input logic            mbtb_en
);
   a_r2_qualify: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && qual_ok) |=> (mode == 2'b01));

   a_r2_hold_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !qual_ok) |=> (mode == 2'b00));

   a_r3_probe_resolves: assert property (@(posedge clk) disable iff (!rst_n)
      tchk_vld |=> ((alloc_vld && alloc_id == $past(tchk_id)) ||
                    (bupd_vld && bupd_id == $past(tchk_id))));

   a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({alloc_vld, bupd_vld}) <= 1);

   a_r3_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
      !tchk_vld |=> (!alloc_vld && !bupd_vld));

   a_r4_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (mode != 2'b10));

   a_r6_fetch_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> !fetch_en);

   a_r6_mbtb_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b10) |-> (mbtb_en && fetch_en));

   a_r8_mispredict: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && mispredict) |=> (mode == 2'b00 && fetch_en));

   a_r9_no_probe_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> !tchk_vld);
endmodule

bind uoc_mode_ctrl uoc_mode_chk #(.ID_W(ID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .qual_ok    (qual_ok),
   .mispredict (mispredict),
   .mode       (mode),
   .tchk_vld   (tchk_vld),
   .tchk_id    (tchk_id),
   .alloc_vld  (alloc_vld),
   .alloc_id   (alloc_id),
   .bupd_vld   (bupd_vld),
   .bupd_id    (bupd_id),
   .fetch_en   (fetch_en),
   .mbtb_en    (mbtb_en)
);

// File: tb/sim_uoc_mode_ctrl.sv
`timescale 1ns/100ps
module sim_uoc_mode_ctrl;
   localparam int ID_W = 8;
   localparam int TO   = 64;
   localparam int ENM  = 4;
   localparam int EXM  = 2;
   localparam int MINF = 8;
   localparam int ACCR = 4;
   localparam int CMAXV = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic look_vld = 1'b0, look_built = 1'b0, qual_ok = 1'b0;
   logic tag_present = 1'b0, mispredict = 1'b0;
   logic [ID_W-1:0] look_id = '0;
   logic [1:0] mode;
   logic tchk_vld, alloc_vld, bupd_vld, fetch_en, mbtb_en;
   logic [ID_W-1:0] tchk_id, alloc_id, bupd_id;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit pres_next = 1'b0;

   always #2.5 clk = ~clk;

   uoc_mode_ctrl #(.ID_W(ID_W), .CNT_W(8), .BUILD_TIMEOUT(TO), .ENTER_MULT(ENM),
                   .EXIT_MULT(EXM), .MIN_FETCH(MINF), .ACC_RUN(ACCR)) u0 (
      .clk(clk), .rst_n(rst_n), .look_vld(look_vld), .look_built(look_built),
      .look_id(look_id), .qual_ok(qual_ok), .tag_present(tag_present),
      .mispredict(mispredict), .mode(mode), .tchk_vld(tchk_vld), .tchk_id(tchk_id),
      .alloc_vld(alloc_vld), .alloc_id(alloc_id), .bupd_vld(bupd_vld),
      .bupd_id(bupd_id), .fetch_en(fetch_en), .mbtb_en(mbtb_en));

   // Behavioural reference model
   int m_mode = 0, m_t = 0, m_b = 0, m_f = 0, m_acc = 0;
   int m_pv = 0, m_pid = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_t = 0; m_b = 0; m_f = 0; m_acc = 0; m_pv = 0; m_pid = 0;
      end else begin
         int nm;
         nm = m_mode;
         if (m_mode == 0 && qual_ok) nm = 1;
         else if (m_mode == 1) begin
            if (m_t >= TO) nm = 0;
            else if (m_f >= ENM * m_b && m_f >= MINF) nm = 2;
         end else if (m_mode == 2) begin
            if (mispredict || EXM * m_b >= m_f) nm = 0;
         end
         m_pv  = (look_vld && !look_built && m_mode != 0) ? 1 : 0;
         if (m_pv != 0) m_pid = look_id;
         if (m_mode == 2 && nm == 2) begin
            if (look_vld && m_acc < ACCR) m_acc++;
         end else m_acc = 0;
         if (m_mode == 0 || nm == 0) begin
            m_t = 0; m_b = 0; m_f = 0;
         end else if (look_vld) begin
            if (look_built) begin if (m_f < CMAXV) m_f++; end
            else begin if (m_b < CMAXV) m_b++; end
            if (m_mode == 1 && m_t < TO) m_t++;
         end
         m_mode = nm;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int e_tchk, e_alloc, e_bupd;
      e_tchk  = (look_vld && !look_built && m_mode != 0) ? 1 : 0;
      e_alloc = (m_pv != 0 && !tag_present) ? 1 : 0;
      e_bupd  = (m_pv != 0 && tag_present) ? 1 : 0;
      chk(int'(mode) == m_mode, "R5 mode vs model", mode, m_mode);
      chk(int'(tchk_vld) == e_tchk, "R3 tchk_vld", tchk_vld, e_tchk);
      if (e_tchk != 0) chk(int'(tchk_id) == int'(look_id), "R3 tchk_id", tchk_id, look_id);
      chk(int'(alloc_vld) == e_alloc, "R3 alloc_vld", alloc_vld, e_alloc);
      chk(int'(bupd_vld) == e_bupd, "R3 bupd_vld", bupd_vld, e_bupd);
      if (e_alloc != 0) chk(int'(alloc_id) == m_pid, "R3 alloc_id", alloc_id, m_pid);
      if (e_bupd != 0)  chk(int'(bupd_id) == m_pid, "R3 bupd_id", bupd_id, m_pid);
      chk(int'(fetch_en) == (m_mode != 2 ? 1 : 0), "R6 fetch_en", fetch_en, m_mode != 2);
      chk(int'(mbtb_en) == ((m_mode == 2 && m_acc == ACCR) ? 0 : 1), "R6 mbtb_en",
          mbtb_en, !(m_mode == 2 && m_acc == ACCR));
   endtask

   // One cycle: drive at negedge, compare, advance.
   task automatic step(input bit lv, input bit lb, input int id, input bit pres,
                       input bit q, input bit mp);
      tag_present = pres_next;
      pres_next   = lv && !lb && pres;
      look_vld    = lv;
      look_built  = lb;
      look_id     = ID_W'(id);
      qual_ok     = q;
      mispredict  = mp;
      #1;
      compare_all();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      step(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(mode == 2'b00, "R1 mode", mode, 0);
      chk(fetch_en && mbtb_en, "R1 enables", {fetch_en, mbtb_en}, 3);
      chk(!tchk_vld && !alloc_vld && !bupd_vld, "R1 requests",
          {tchk_vld, alloc_vld, bupd_vld}, 0);
      @(negedge clk);

      // R9 filter: lookups ignored, mispredict ignored
      for (int i = 0; i < 4; i++) step(1'b1, i[0], 10 + i, 1'b0, 1'b0, 1'b1);
      chk(mode == 2'b00, "R9 filter stays", mode, 0);

      // R2 qualify into build
      step(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
      chk(mode == 2'b01, "R2 enter build", mode, 1);

      // R3 two unbuilt lookups: first absent, second present
      step(1'b1, 1'b0, 1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 2, 1'b1, 1'b0, 1'b0);
      idle();
      // R4 eight built lookups reach 8 >= 4*2
      for (int i = 0; i < 8; i++) begin
         step(1'b1, 1'b1, 20 + i, 1'b0, 1'b0, 1'b0);
         if (i == 6) chk(mode == 2'b01, "R4 not before threshold", mode, 1);
      end
      idle();
      chk(mode == 2'b10, "R4 enter fetch", mode, 2);
      chk(!fetch_en, "R6 fetch gated", fetch_en, 0);

      // R6 accuracy run gates main buffer
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 30 + i, 1'b0, 1'b0, 1'b0);
      chk(!mbtb_en, "R6 mbtb gated", mbtb_en, 0);

      // R7 unbuilt edges grow to 6 against 12 built
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 40 + i, i[0], 1'b0, 1'b0);
      idle();
      chk(mode == 2'b10, "R7 still fetch at 5", mode, 2);
      step(1'b1, 1'b0, 44, 1'b0, 1'b0, 1'b0);
      idle();
      chk(mode == 2'b00, "R7 exit to filter", mode, 0);

      // R8 mispredict leaves fetch
      step(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 50 + i, 1'b0, 1'b0, 1'b0);
      idle();
      chk(mode == 2'b10, "R8 setup fetch", mode, 2);
      step(1'b1, 1'b1, 60, 1'b0, 1'b0, 1'b1);
      chk(mode == 2'b00, "R8 back to filter", mode, 0);
      chk(fetch_en, "R8 fetch re-enabled", fetch_en, 1);

      // R5 timeout, with mispredict in build ignored (R9)
      step(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1);
      chk(mode == 2'b01, "R9 build ignores mispredict", mode, 1);
      for (int i = 0; i < TO; i++) step(1'b1, 1'b0, i, i[0], 1'b0, 1'b0);
      chk(mode == 2'b01, "R5 at timeout edge", mode, 1);
      idle();
      chk(mode == 2'b00, "R5 timeout to filter", mode, 0);
      // counts cleared: requalify, 8 built lookups enter fetch immediately
      step(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 70 + i, 1'b0, 1'b0, 1'b0);
      idle();
      chk(mode == 2'b10, "R5 counts cleared", mode, 2);
      idle();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule